// File: doc/BRIEF.md
# Segmented-Page Address Translator

This block maps a 20-bit logical address onto a 20-bit physical word address. The logical address is split into a 4-bit segment number, an 8-bit page number and an 8-bit word offset. The segment number selects one of 16 segment entries. Each segment entry holds an 8-bit base. The base plus the page number indexes a 256-entry page table. A page entry holds a 12-bit block number, a presence bit and a 2-bit access-rights code. The physical address is the block number with the word offset appended below it.

An 8-entry, fully associative translation buffer sits in front of the tables. It holds recent segment-and-page pairs with their block and rights, so a repeated access skips the two-step table walk. Both tables are loaded through dedicated write ports. Each translation request carries an access type (read, write or fetch) and a privileged flag. The response reports either a physical address, a page fault or a protection fault.

Top module: `segxl_top`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0. Both tables are cleared (base 0, page not present) and the buffer is empty, so any translation reports a page fault.
- R2: The page-table index is (segment base + page number) mod 256. The physical address is {block, word offset}. With segment 6 at base 0x35 and page entry 0x37 holding block 0x019, logical 0x6027E gives physical 0x0197E.
- R3: A request that misses the buffer is accepted on a clock edge. `req_ready` is low for the next two cycles, and `rsp_valid` rises after the third edge counted from the accepting edge, with `rsp_hit` = 0.
- R4: A request whose segment and page are held in the buffer gets its response after the accepting edge, with `rsp_hit` = 1. The address uses the buffered block and the new word offset.
- R5: A page entry whose presence bit is 0 gives `rsp_page_fault` = 1 and `rsp_paddr` = 0. Such an entry is not put in the buffer, so a repeat walks the tables again.
- R6: Request type codes are 00 read, 01 write and 10 fetch. Rights code 00 allows read and write. Code 01 allows read only. Code 10 allows fetch only. Code 11 allows read, write or fetch only when `req_priv` = 1. Type 11 is always refused. A refused access gives `rsp_prot_fault` = 1 and `rsp_paddr` = 0.
- R7: A walk that ends in a protection fault on a present page still fills the buffer. Later hits apply the rights check to their own access type.
- R8: Any write to either table empties the whole buffer. A request accepted in the same cycle as a table write is handled as a miss.
- R9: Buffer fills go to entries 0, 1, ..., 7 in turn and then wrap to entry 0. Emptying the buffer returns the fill position to entry 0.
- R10: A request presented while `req_ready` is 0 is ignored and produces no response.
- R11: The page-table index wraps modulo 256. Base 0xF0 plus page 0x20 indexes page entry 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seg_wr_en | input | 1 | Segment table write strobe |
| seg_wr_sel | input | 4 | Segment entry to write |
| seg_wr_base | input | 8 | Page-table base to store |
| pt_wr_en | input | 1 | Page table write strobe |
| pt_wr_idx | input | 8 | Page entry to write |
| pt_wr_block | input | 12 | Block number to store |
| pt_wr_present | input | 1 | Presence bit to store |
| pt_wr_rights | input | 2 | Rights code to store |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_laddr | input | 20 | Logical address {segment, page, word} |
| req_acc | input | 2 | Access type: 00 read, 01 write, 10 fetch |
| req_priv | input | 1 | Privileged request |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | 20 | Physical address {block, word}, zero on fault |
| rsp_hit | output | 1 | Response came from the buffer |
| rsp_page_fault | output | 1 | Page not present |
| rsp_prot_fault | output | 1 | Access rights refused |

## Verification
The hardest behaviour to reach from the ports is the buffer replacement order. Whether an entry was evicted shows only in response latency. To test it, the bench loads nine present pages, which also empties the buffer and resets the fill position. It walks all nine so the ninth overwrites the first. It then checks that the ninth and eighth still hit and the first misses. Two other cases need exact cycle alignment. In one, a table write lands in the same cycle as a request that would otherwise hit. In the other, a new request is held during both walk cycles and must produce no extra response.

// File: rtl/segxl_pkg.sv
package segxl_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_BAD   = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        RT_RW  = 2'b00,
        RT_RO  = 2'b01,
        RT_XO  = 2'b10,
        RT_SYS = 2'b11
    } rights_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_SEG  = 2'b01,
        ST_PT   = 2'b10
    } walk_e;

    function automatic logic rights_ok(input logic [1:0] rts, input logic [1:0] acc,
                                       input logic priv);
        logic ok;
        case (rights_e'(rts))
            RT_RW:   ok = (acc_e'(acc) == ACC_READ) || (acc_e'(acc) == ACC_WRITE);
            RT_RO:   ok = (acc_e'(acc) == ACC_READ);
            RT_XO:   ok = (acc_e'(acc) == ACC_FETCH);
            default: ok = priv && (acc_e'(acc) != ACC_BAD);
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/segxl_seg_table.sv
module segxl_seg_table #(
    parameter int SEG_W  = 4,
    parameter int BASE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEG_W-1:0]  waddr,
    input  logic [BASE_W-1:0] wdata,
    input  logic [SEG_W-1:0]  raddr,
    output logic [BASE_W-1:0] rdata
);
    localparam int DEPTH = 1 << SEG_W;

    logic [BASE_W-1:0] base_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) base_q[i] <= '0;
        end else if (we) begin
            base_q[waddr] <= wdata;
        end
    end

    assign rdata = base_q[raddr];
endmodule

// File: rtl/segxl_page_table.sv
module segxl_page_table #(
    parameter int IDX_W = 8,
    parameter int BLK_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [BLK_W-1:0] wblk,
    input  logic             wpres,
    input  logic [1:0]       wrts,
    input  logic [IDX_W-1:0] raddr,
    output logic [BLK_W-1:0] rblk,
    output logic             rpres,
    output logic [1:0]       rrts
);
    localparam int DEPTH = 1 << IDX_W;

    logic [BLK_W-1:0] blk_q  [DEPTH];
    logic             pres_q [DEPTH];
    logic [1:0]       rts_q  [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                blk_q[i]  <= '0;
                pres_q[i] <= 1'b0;
                rts_q[i]  <= '0;
            end
        end else if (we) begin
            blk_q[waddr]  <= wblk;
            pres_q[waddr] <= wpres;
            rts_q[waddr]  <= wrts;
        end
    end

    assign rblk  = blk_q[raddr];
    assign rpres = pres_q[raddr];
    assign rrts  = rts_q[raddr];
endmodule

// File: rtl/segxl_tlb.sv
module segxl_tlb #(
    parameter int N     = 8,
    parameter int TAG_W = 12,
    parameter int BLK_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] look_tag,
    output logic             hit,
    output logic [BLK_W-1:0] hit_blk,
    output logic [1:0]       hit_rts,
    input  logic             fill,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [BLK_W-1:0] fill_blk,
    input  logic [1:0]       fill_rts,
    input  logic             inval
);
    localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [N-1:0]            vld;
        logic [N-1:0][TAG_W-1:0] tag;
        logic [N-1:0][BLK_W-1:0] blk;
        logic [N-1:0][1:0]       rts;
        logic [PTR_W-1:0]        ptr;
    } tlb_st_t;

    tlb_st_t st_d, st_q;
    logic [N-1:0] match;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = st_q.vld[g] && (st_q.tag[g] == look_tag);
    end

    always_comb begin
        hit_blk = '0;
        hit_rts = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) begin
                hit_blk = hit_blk | st_q.blk[i];
                hit_rts = hit_rts | st_q.rts[i];
            end
        end
    end
    assign hit = |match;

    always_comb begin
        st_d = st_q;
        if (inval) begin
            st_d.vld = '0;
            st_d.ptr = '0;
        end else if (fill) begin
            st_d.vld[st_q.ptr] = 1'b1;
            st_d.tag[st_q.ptr] = fill_tag;
            st_d.blk[st_q.ptr] = fill_blk;
            st_d.rts[st_q.ptr] = fill_rts;
            st_d.ptr = (st_q.ptr == PTR_W'(N - 1)) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    tlb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match));
    // R8
    tlb_flush_chk: assert property (@(posedge clk) disable iff (!rst_n) inval |=> (st_q.vld == '0));
    // R9
    tlb_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill && !inval) |=> st_q.vld[$past(st_q.ptr)]);
endmodule

// File: rtl/segxl_top.sv
module segxl_top
    import segxl_pkg::*;
#(
    parameter int SEG_W  = 4,
    parameter int PAGE_W = 8,
    parameter int WORD_W = 8,
    parameter int BLK_W  = 12,
    parameter int TLB_N  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      seg_wr_en,
    input  logic [SEG_W-1:0]          seg_wr_sel,
    input  logic [PAGE_W-1:0]         seg_wr_base,
    input  logic                      pt_wr_en,
    input  logic [PAGE_W-1:0]         pt_wr_idx,
    input  logic [BLK_W-1:0]          pt_wr_block,
    input  logic                      pt_wr_present,
    input  logic [1:0]                pt_wr_rights,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [SEG_W+PAGE_W+WORD_W-1:0] req_laddr,
    input  logic [1:0]                req_acc,
    input  logic                      req_priv,
    output logic                      rsp_valid,
    output logic [BLK_W+WORD_W-1:0]   rsp_paddr,
    output logic                      rsp_hit,
    output logic                      rsp_page_fault,
    output logic                      rsp_prot_fault
);
    localparam int LA_W  = SEG_W + PAGE_W + WORD_W;
    localparam int PA_W  = BLK_W + WORD_W;
    localparam int TAG_W = SEG_W + PAGE_W;

    typedef struct packed {
        walk_e             st;
        logic [TAG_W-1:0]  tag;
        logic [WORD_W-1:0] word;
        logic [1:0]        acc;
        logic              priv;
        logic [PAGE_W-1:0] idx;
        logic              rv;
        logic [PA_W-1:0]   pa;
        logic              hit;
        logic              pf;
        logic              prf;
    } xl_st_t;

    xl_st_t s_d, s_q;

    logic              tbl_wr, accept, use_hit, fill;
    logic [TAG_W-1:0]  look_tag;
    logic              tlb_hit;
    logic [BLK_W-1:0]  tlb_blk, pt_blk;
    logic [1:0]        tlb_rts, pt_rts;
    logic [PAGE_W-1:0] seg_base;
    logic              pt_pres;

    assign tbl_wr   = seg_wr_en | pt_wr_en;
    assign req_ready = (s_q.st == ST_IDLE);
    assign accept   = req_valid && req_ready;
    assign look_tag = req_laddr[LA_W-1:WORD_W];
    assign use_hit  = tlb_hit && !tbl_wr;

    segxl_seg_table #(.SEG_W(SEG_W), .BASE_W(PAGE_W)) i_seg (
        .clk(clk), .rst_n(rst_n), .we(seg_wr_en), .waddr(seg_wr_sel), .wdata(seg_wr_base),
        .raddr(s_q.tag[TAG_W-1:PAGE_W]), .rdata(seg_base));

    segxl_page_table #(.IDX_W(PAGE_W), .BLK_W(BLK_W)) i_pt (
        .clk(clk), .rst_n(rst_n), .we(pt_wr_en), .waddr(pt_wr_idx), .wblk(pt_wr_block),
        .wpres(pt_wr_present), .wrts(pt_wr_rights), .raddr(s_q.idx),
        .rblk(pt_blk), .rpres(pt_pres), .rrts(pt_rts));

    segxl_tlb #(.N(TLB_N), .TAG_W(TAG_W), .BLK_W(BLK_W)) i_tlb (
        .clk(clk), .rst_n(rst_n), .look_tag(look_tag), .hit(tlb_hit), .hit_blk(tlb_blk),
        .hit_rts(tlb_rts), .fill(fill), .fill_tag(s_q.tag), .fill_blk(pt_blk),
        .fill_rts(pt_rts), .inval(tbl_wr));

    always_comb begin
        s_d     = s_q;
        s_d.rv  = 1'b0;
        s_d.pa  = '0;
        s_d.hit = 1'b0;
        s_d.pf  = 1'b0;
        s_d.prf = 1'b0;
        fill    = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (accept) begin
                    s_d.tag  = look_tag;
                    s_d.word = req_laddr[WORD_W-1:0];
                    s_d.acc  = req_acc;
                    s_d.priv = req_priv;
                    if (use_hit) begin
                        s_d.rv  = 1'b1;
                        s_d.hit = 1'b1;
                        if (rights_ok(tlb_rts, req_acc, req_priv))
                            s_d.pa = {tlb_blk, req_laddr[WORD_W-1:0]};
                        else
                            s_d.prf = 1'b1;
                    end else begin
                        s_d.st = ST_SEG;
                    end
                end
            end
            ST_SEG: begin
                s_d.idx = seg_base + s_q.tag[PAGE_W-1:0];
                s_d.st  = ST_PT;
            end
            default: begin
                s_d.rv = 1'b1;
                s_d.st = ST_IDLE;
                if (!pt_pres) begin
                    s_d.pf = 1'b1;
                end else begin
                    fill = 1'b1;
                    if (rights_ok(pt_rts, s_q.acc, s_q.priv))
                        s_d.pa = {pt_blk, s_q.word};
                    else
                        s_d.prf = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsp_valid      = s_q.rv;
    assign rsp_paddr      = s_q.pa;
    assign rsp_hit        = s_q.hit;
    assign rsp_page_fault = s_q.pf;
    assign rsp_prot_fault = s_q.prf;

    // R3
    miss_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !use_hit) |=> (!req_ready && !rsp_valid));
    // R3
    walk_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_SEG) |=> (s_q.st == ST_PT && !req_ready));
    // R5
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_page_fault || rsp_prot_fault) |-> (rsp_valid && rsp_paddr == '0));
    // R6
    fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_page_fault && rsp_prot_fault));
    // R4
    hit_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_valid && !rsp_page_fault && $past(req_ready)));
endmodule

// File: tb/test_segxl_top.sv
`timescale 1ns/1ps
module test_segxl_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_wr_en = 1'b0;
    logic [3:0]  seg_wr_sel = '0;
    logic [7:0]  seg_wr_base = '0;
    logic        pt_wr_en = 1'b0;
    logic [7:0]  pt_wr_idx = '0;
    logic [11:0] pt_wr_block = '0;
    logic        pt_wr_present = 1'b0;
    logic [1:0]  pt_wr_rights = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_laddr = '0;
    logic [1:0]  req_acc = '0;
    logic        req_priv = 1'b0;
    logic        rsp_valid;
    logic [19:0] rsp_paddr;
    logic        rsp_hit, rsp_page_fault, rsp_prot_fault;

    int n_chk = 0;
    int n_bad = 0;
    logic [19:0] r_pa;
    logic r_pf, r_prf, r_hit;
    int r_lat;

    always #10 clk = ~clk;

    segxl_top i_segxl_top (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_seg(input logic [3:0] s, input logic [7:0] b);
        @(negedge clk);
        seg_wr_en = 1'b1; seg_wr_sel = s; seg_wr_base = b;
        @(negedge clk);
        seg_wr_en = 1'b0;
    endtask

    task automatic wr_pt(input logic [7:0] i, input logic [11:0] b, input logic p,
                         input logic [1:0] r);
        @(negedge clk);
        pt_wr_en = 1'b1; pt_wr_idx = i; pt_wr_block = b; pt_wr_present = p; pt_wr_rights = r;
        @(negedge clk);
        pt_wr_en = 1'b0;
    endtask

    task automatic do_req(input logic [19:0] la, input logic [1:0] acc, input logic pr,
                          input logic wr_same);
        @(negedge clk);
        if (wr_same) begin
            seg_wr_en = 1'b1; seg_wr_sel = 4'hE; seg_wr_base = 8'h00;
        end
        req_valid = 1'b1; req_laddr = la; req_acc = acc; req_priv = pr;
        @(negedge clk);
        req_valid = 1'b0; seg_wr_en = 1'b0;
        r_lat = 1;
        while (!rsp_valid && r_lat < 8) begin
            @(negedge clk);
            r_lat++;
        end
        r_pa = rsp_paddr; r_pf = rsp_page_fault; r_prf = rsp_prot_fault; r_hit = rsp_hit;
    endtask

    task automatic expect_rsp(input string tag, input logic [19:0] pa, input logic pf,
                              input logic prf, input logic hit, input int lat);
        chk({tag, " paddr"}, 32'(r_pa), 32'(pa));
        chk({tag, " page_fault"}, 32'(r_pf), 32'(pf));
        chk({tag, " prot_fault"}, 32'(r_prf), 32'(prf));
        chk({tag, " hit"}, 32'(r_hit), 32'(hit));
        chk({tag, " latency"}, 32'(r_lat), 32'(lat));
    endtask

    task automatic t_reset;
        chk("R1 ready after reset", 32'(req_ready), 32'd1);
        chk("R1 no response after reset", 32'(rsp_valid), 32'd0);
        do_req(20'h00000, 2'b00, 1'b0, 1'b0);
        expect_rsp("R1 cleared tables", 20'h0, 1'b1, 1'b0, 1'b0, 3);
    endtask

    task automatic t_example;
        wr_seg(4'h6, 8'h35);
        wr_pt(8'h37, 12'h019, 1'b1, 2'b00);
        do_req(20'h6027E, 2'b00, 1'b0, 1'b0);
        expect_rsp("R2 R3 walk", 20'h0197E, 1'b0, 1'b0, 1'b0, 3);
        do_req(20'h60211, 2'b00, 1'b0, 1'b0);
        expect_rsp("R4 hit", 20'h01911, 1'b0, 1'b0, 1'b1, 1);
    endtask

    task automatic t_wrap;
        wr_seg(4'hF, 8'hF0);
        wr_pt(8'h10, 12'hABC, 1'b1, 2'b00);
        do_req(20'hF2055, 2'b00, 1'b0, 1'b0);
        expect_rsp("R11 index wrap", 20'hABC55, 1'b0, 1'b0, 1'b0, 3);
    endtask

    task automatic t_absent;
        do_req(20'h60300, 2'b00, 1'b0, 1'b0);
        expect_rsp("R5 absent page", 20'h0, 1'b1, 1'b0, 1'b0, 3);
        do_req(20'h60301, 2'b00, 1'b0, 1'b0);
        expect_rsp("R5 absent not buffered", 20'h0, 1'b1, 1'b0, 1'b0, 3);
    endtask

    task automatic t_rights;
        wr_pt(8'h39, 12'h101, 1'b1, 2'b01);
        wr_pt(8'h3A, 12'h102, 1'b1, 2'b10);
        wr_pt(8'h3B, 12'h103, 1'b1, 2'b11);
        do_req(20'h60400, 2'b01, 1'b0, 1'b0);
        expect_rsp("R6 read-only write", 20'h0, 1'b0, 1'b1, 1'b0, 3);
        do_req(20'h60401, 2'b00, 1'b0, 1'b0);
        expect_rsp("R7 faulted walk filled", 20'h10101, 1'b0, 1'b0, 1'b1, 1);
        do_req(20'h60402, 2'b10, 1'b0, 1'b0);
        expect_rsp("R7 read-only fetch on hit", 20'h0, 1'b0, 1'b1, 1'b1, 1);
        do_req(20'h60510, 2'b10, 1'b0, 1'b0);
        expect_rsp("R6 execute-only fetch", 20'h10210, 1'b0, 1'b0, 1'b0, 3);
        do_req(20'h60511, 2'b00, 1'b0, 1'b0);
        expect_rsp("R6 execute-only read", 20'h0, 1'b0, 1'b1, 1'b1, 1);
        do_req(20'h60620, 2'b00, 1'b0, 1'b0);
        expect_rsp("R6 system user read", 20'h0, 1'b0, 1'b1, 1'b0, 3);
        do_req(20'h60621, 2'b00, 1'b1, 1'b0);
        expect_rsp("R6 system priv read", 20'h10321, 1'b0, 1'b0, 1'b1, 1);
        do_req(20'h60630, 2'b01, 1'b1, 1'b0);
        expect_rsp("R6 system priv write", 20'h10330, 1'b0, 1'b0, 1'b1, 1);
        do_req(20'h60233, 2'b01, 1'b0, 1'b0);
        expect_rsp("R6 read-write write", 20'h01933, 1'b0, 1'b0, 1'b0, 3);
        do_req(20'h60234, 2'b10, 1'b0, 1'b0);
        expect_rsp("R6 read-write fetch", 20'h0, 1'b0, 1'b1, 1'b1, 1);
        do_req(20'h60235, 2'b11, 1'b1, 1'b0);
        expect_rsp("R6 type 11 refused", 20'h0, 1'b0, 1'b1, 1'b1, 1);
    endtask

    task automatic t_flush;
        do_req(20'h6027E, 2'b00, 1'b0, 1'b0);
        expect_rsp("R8 before flush", 20'h0197E, 1'b0, 1'b0, 1'b1, 1);
        wr_seg(4'hE, 8'h00);
        do_req(20'h6027E, 2'b00, 1'b0, 1'b0);
        expect_rsp("R8 after flush", 20'h0197E, 1'b0, 1'b0, 1'b0, 3);
        do_req(20'h6027E, 2'b00, 1'b0, 1'b1);
        expect_rsp("R8 same-cycle write", 20'h0197E, 1'b0, 1'b0, 1'b0, 3);
        do_req(20'h6027E, 2'b00, 1'b0, 1'b0);
        expect_rsp("R8 refilled", 20'h0197E, 1'b0, 1'b0, 1'b1, 1);
    endtask

    task automatic t_busy;
        int extra;
        wr_seg(4'hE, 8'h00);
        @(negedge clk);
        req_valid = 1'b1; req_laddr = 20'hF2055; req_acc = 2'b00; req_priv = 1'b0;
        @(negedge clk);
        chk("R3 ready low in walk", 32'(req_ready), 32'd0);
        req_laddr = 20'h60400;
        @(negedge clk);
        chk("R3 ready low second walk cycle", 32'(req_ready), 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 first response valid", 32'(rsp_valid), 32'd1);
        chk("R10 first response address", 32'(rsp_paddr), 32'h000ABC55);
        extra = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (rsp_valid) extra++;
        end
        chk("R10 busy request ignored", 32'(extra), 32'd0);
    endtask

    task automatic t_rr;
        wr_seg(4'h3, 8'h80);
        for (int p = 0; p < 9; p++) wr_pt(8'h80 + 8'(p), 12'h200 + 12'(p), 1'b1, 2'b00);
        for (int p = 0; p < 9; p++) begin
            do_req({4'h3, 8'(p), 8'h00}, 2'b00, 1'b0, 1'b0);
            chk("R9 fill walk", 32'(r_lat), 32'd3);
        end
        do_req(20'h30805, 2'b00, 1'b0, 1'b0);
        expect_rsp("R9 ninth kept", 20'h20805, 1'b0, 1'b0, 1'b1, 1);
        do_req(20'h30006, 2'b00, 1'b0, 1'b0);
        expect_rsp("R9 first evicted", 20'h20006, 1'b0, 1'b0, 1'b0, 3);
        do_req(20'h30707, 2'b00, 1'b0, 1'b0);
        expect_rsp("R9 eighth kept", 20'h20707, 1'b0, 1'b0, 1'b1, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_example();
        t_wrap();
        t_absent();
        t_rights();
        t_flush();
        t_busy();
        t_rr();
        repeat (2) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule